// File: doc/BRIEF.md
# Big-Number Engine Launch and Result-Stall Controller

This block is the control and status logic in front of a big-number arithmetic engine. The host writes a function word that carries a run bit, a result-stall bit and a code that picks a complex sequencer operation. When run is set, the block pulses a start strobe to the datapath. When the datapath reports a finished basic operation, the block latches the compare flags and the two most-significant-word results into host-visible registers and drops run. The interrupt output is the complement of the host's view of run.

The host may ask for publication to be held back. With the stall bit set, a finishing basic operation parks its result in a side buffer and leaves run high. The host can then read the previous result at leisure and release the new one by clearing the stall bit. A second control word holds the sequencer reset bit and an 8-bit trigger field. The host can only set trigger bits and the sequencer can only clear them. The sequencer reset bit also decides whether the host reaches program memory or data memory.

Top module: `bn_launch_ctrl`

## Requirements
- R1: After reset, run reads 1, irq is 0, the trigger field, the status field, the stall bit, the operation code and all result registers are 0, and the sequencer reset bit equals the PROG_IN_RAM parameter (1 for program in RAM, 0 for program in ROM).
- R2: The host-visible run is the internal run flag ORed with the complement of sequencer status bit 0, and irq is always the complement of that host-visible run.
- R3: A function write (host_sel=0) uses host_wdata bit 0 as run, bit 1 as stall and bits [4:2] as the operation code. Writing run=1 while run reads 0 raises dp_start for exactly the next cycle, and run reads 1 from then on.
- R4: A dp_done pulse during a basic operation (code 0) with stall 0 loads dp_cmp, dp_msw and dp_divmsw into cmp_rd, msw_rd and divmsw_rd and clears run, all visible one cycle after the pulse.
- R5: A dp_done pulse during a basic operation with stall 1 leaves the result registers unchanged and leaves run at 1, and the result is held pending.
- R6: A function write that clears stall while a result is pending makes the pending values appear in the result registers, and run clear, one cycle after the cycle in which stall reads 0.
- R7: During a complex operation (nonzero code), dp_done is ignored. The operation ends only through seq_run_clr, which clears run even while stall is 1.
- R8: A control write (host_sel=1) ORs host_wdata bits [15:8] into the trigger field. Zero bits in that write change nothing.
- R9: A sequencer trigger write ANDs seq_trig_wdata into the trigger field, so one bits change nothing. When a host set and a sequencer clear hit the same bit in the same cycle, the set wins.
- R10: A function write that starts an operation with a nonzero code also sets trigger bit 0 in the same cycle.
- R11: While run reads 1, a function write changes only the stall bit, and a control write cannot set the sequencer reset bit. Clearing the sequencer reset bit is always allowed.
- R12: With PROG_IN_RAM=1, prog_mem_en equals the sequencer reset bit and data_mem_en is its complement. While the sequencer reset bit is 1, seq_trig_wr, seq_stat_wr and seq_run_clr are ignored.
- R13: With PROG_IN_RAM=0, prog_mem_en stays 0 and data_mem_en stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 selects the function word, 1 the control word |
| host_wdata | input | 16 | Host write data |
| run_rd | output | 1 | Host-visible run |
| stall_rd | output | 1 | Result-stall bit |
| op_rd | output | 3 | Complex operation code |
| seq_rst_rd | output | 1 | Sequencer reset bit |
| trig_rd | output | 8 | Host-to-sequencer trigger field |
| stat_rd | output | 8 | Sequencer status field |
| cmp_rd | output | 3 | Published compare flags |
| msw_rd | output | 12 | Published most-significant-word result |
| divmsw_rd | output | 12 | Published remainder most-significant-word result |
| irq | output | 1 | Interrupt, complement of run_rd |
| prog_mem_en | output | 1 | Host access to program memory |
| data_mem_en | output | 1 | Host access to data memory |
| dp_start | output | 1 | One-cycle start strobe to the datapath |
| dp_done | input | 1 | Datapath completion pulse |
| dp_cmp | input | 3 | Compare flags from the datapath |
| dp_msw | input | 12 | Most-significant-word result from the datapath |
| dp_divmsw | input | 12 | Remainder most-significant-word result from the datapath |
| seq_trig_wr | input | 1 | Sequencer trigger write strobe |
| seq_trig_wdata | input | 8 | Sequencer trigger data, zeros clear bits |
| seq_stat_wr | input | 1 | Sequencer status write strobe |
| seq_stat_wdata | input | 8 | Sequencer status data |
| seq_run_clr | input | 1 | Sequencer request to clear run |

## Verification
The bench builds the main instance with the default widths and PROG_IN_RAM=1. This covers the reset path in which the sequencer is held, program memory is open to the host and sequencer inputs must be ignored. A second instance with PROG_IN_RAM=0 brings the program-in-ROM reset value and the fixed memory routing within reach. The 12-bit result width lets random dp_msw and dp_divmsw values exercise every bit of the stall buffer across many randomly stalled and released basic operations.

// File: rtl/bnl_pkg.sv
package bnl_pkg;
  // host register select
  localparam logic SEL_FUNC = 1'b0;
  localparam logic SEL_CTRL = 1'b1;

  // function word bit positions
  localparam int F_RUN   = 0;
  localparam int F_STALL = 1;
  localparam int F_OP_LO = 2;

  // control word bit positions
  localparam int C_RST     = 0;
  localparam int C_TRIG_LO = 8;

  // host-visible run: internal flag, or sequencer not yet ready
  function automatic logic run_view(input logic run_flag, input logic stat0);
    return run_flag | ~stat0;
  endfunction
endpackage

// File: rtl/bnl_func_reg.sv
module bnl_func_reg #(
  parameter int OP_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            w_run,
  input  logic            w_stall,
  input  logic [OP_W-1:0] w_op,
  input  logic            run_vis,
  input  logic            clr_run,
  output logic            run_q,
  output logic            stall_q,
  output logic [OP_W-1:0] op_q,
  output logic            start_q,
  output logic            launch_evt,
  output logic            auto_trig
);
  logic full_wr;

  assign full_wr    = wr & ~run_vis;
  assign launch_evt = full_wr & w_run;
  assign auto_trig  = launch_evt & (w_op != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b1;
      stall_q <= 1'b0;
      op_q    <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= launch_evt;
      if (wr) stall_q <= w_stall;
      if (full_wr) op_q <= w_op;
      if (launch_evt) run_q <= 1'b1;
      else if (clr_run) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bnl_result_ctrl.sv
module bnl_result_ctrl #(
  parameter int CMP_W = 3,
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dp_done,
  input  logic [CMP_W-1:0] dp_cmp,
  input  logic [RES_W-1:0] dp_msw,
  input  logic [RES_W-1:0] dp_divmsw,
  input  logic             run_q,
  input  logic             basic_op,
  input  logic             stall_q,
  output logic [CMP_W-1:0] cmp_q,
  output logic [RES_W-1:0] msw_q,
  output logic [RES_W-1:0] div_q,
  output logic             pend_q,
  output logic             done_evt,
  output logic             publish_evt
);
  logic [CMP_W-1:0] hold_cmp;
  logic [RES_W-1:0] hold_msw;
  logic [RES_W-1:0] hold_div;
  logic direct_evt, park_evt, release_evt;

  assign done_evt    = dp_done & run_q & basic_op & ~pend_q;
  assign direct_evt  = done_evt & ~stall_q;
  assign park_evt    = done_evt & stall_q;
  assign release_evt = pend_q & ~stall_q;
  assign publish_evt = direct_evt | release_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cmp <= '0;
      hold_msw <= '0;
      hold_div <= '0;
      pend_q   <= 1'b0;
      cmp_q    <= '0;
      msw_q    <= '0;
      div_q    <= '0;
    end else begin
      if (park_evt) begin
        hold_cmp <= dp_cmp;
        hold_msw <= dp_msw;
        hold_div <= dp_divmsw;
        pend_q   <= 1'b1;
      end else if (release_evt) begin
        pend_q <= 1'b0;
      end
      if (direct_evt) begin
        cmp_q <= dp_cmp;
        msw_q <= dp_msw;
        div_q <= dp_divmsw;
      end else if (release_evt) begin
        cmp_q <= hold_cmp;
        msw_q <= hold_msw;
        div_q <= hold_div;
      end
    end
  end
endmodule

// File: rtl/bnl_trig_reg.sv
module bnl_trig_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_set_en,
  input  logic [W-1:0] host_mask,
  input  logic         seq_clr_en,
  input  logic [W-1:0] seq_data,
  input  logic         auto0,
  output logic [W-1:0] trig_q
);
  function automatic logic [W-1:0] trig_next(
    input logic [W-1:0] cur, input logic set_en, input logic [W-1:0] set_m,
    input logic clr_en, input logic [W-1:0] keep_m, input logic a0);
    logic [W-1:0] v;
    v = clr_en ? (cur & keep_m) : cur;
    if (set_en) v = v | set_m;
    v[0] = v[0] | a0;
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= '0;
    else trig_q <= trig_next(trig_q, host_set_en, host_mask, seq_clr_en, seq_data, auto0);
  end
endmodule

// File: rtl/bnl_seq_ctrl.sv
module bnl_seq_ctrl #(
  parameter int STAT_W      = 8,
  parameter bit PROG_IN_RAM = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              w_rst,
  input  logic              run_vis,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic              seq_rst_q,
  output logic              seq_en,
  output logic [STAT_W-1:0] stat_q,
  output logic              prog_en,
  output logic              data_en
);
  localparam logic RST_INIT = PROG_IN_RAM;
  logic rst_wr_ok;

  assign rst_wr_ok = ctrl_wr & (~w_rst | ~run_vis);
  assign seq_en    = ~seq_rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_rst_q <= RST_INIT;
      stat_q    <= '0;
    end else begin
      if (rst_wr_ok) seq_rst_q <= w_rst;
      if (stat_wr && seq_en) stat_q <= stat_wdata;
    end
  end

  generate
    if (PROG_IN_RAM) begin : g_ram_prog
      assign prog_en = seq_rst_q;
      assign data_en = ~seq_rst_q;
    end else begin : g_rom_prog
      assign prog_en = 1'b0;
      assign data_en = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/bn_launch_ctrl.sv
module bn_launch_ctrl #(
  parameter int OP_W        = 3,
  parameter int TRIG_W      = 8,
  parameter int STAT_W      = 8,
  parameter int CMP_W       = 3,
  parameter int AW          = 11,
  parameter bit PROG_IN_RAM = 1'b1,
  localparam int HW_W       = bnl_pkg::C_TRIG_LO + TRIG_W,
  localparam int RES_W      = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [HW_W-1:0]   host_wdata,
  output logic              run_rd,
  output logic              stall_rd,
  output logic [OP_W-1:0]   op_rd,
  output logic              seq_rst_rd,
  output logic [TRIG_W-1:0] trig_rd,
  output logic [STAT_W-1:0] stat_rd,
  output logic [CMP_W-1:0]  cmp_rd,
  output logic [RES_W-1:0]  msw_rd,
  output logic [RES_W-1:0]  divmsw_rd,
  output logic              irq,
  output logic              prog_mem_en,
  output logic              data_mem_en,
  output logic              dp_start,
  input  logic              dp_done,
  input  logic [CMP_W-1:0]  dp_cmp,
  input  logic [RES_W-1:0]  dp_msw,
  input  logic [RES_W-1:0]  dp_divmsw,
  input  logic              seq_trig_wr,
  input  logic [TRIG_W-1:0] seq_trig_wdata,
  input  logic              seq_stat_wr,
  input  logic [STAT_W-1:0] seq_stat_wdata,
  input  logic              seq_run_clr
);
  import bnl_pkg::*;

  logic func_wr, ctrl_wr;
  logic run_q, launch_evt, auto_trig;
  logic done_evt, publish_evt, pend_q;
  logic seq_en, seq_clr_eff, seq_runclr_eff, clr_run;
  logic unused_bits;

  assign func_wr        = host_wr & (host_sel == SEL_FUNC);
  assign ctrl_wr        = host_wr & (host_sel == SEL_CTRL);
  assign seq_clr_eff    = seq_trig_wr & seq_en;
  assign seq_runclr_eff = seq_run_clr & seq_en;
  assign clr_run        = publish_evt | seq_runclr_eff;
  assign run_rd         = run_view(run_q, stat_rd[0]);
  assign irq            = ~run_rd;
  assign unused_bits    = ^host_wdata[C_TRIG_LO-1:F_OP_LO+OP_W];

  bnl_func_reg #(.OP_W(OP_W)) u_func (
    .clk(clk), .rst_n(rst_n), .wr(func_wr),
    .w_run(host_wdata[F_RUN]), .w_stall(host_wdata[F_STALL]),
    .w_op(host_wdata[F_OP_LO +: OP_W]), .run_vis(run_rd), .clr_run(clr_run),
    .run_q(run_q), .stall_q(stall_rd), .op_q(op_rd), .start_q(dp_start),
    .launch_evt(launch_evt), .auto_trig(auto_trig)
  );

  bnl_result_ctrl #(.CMP_W(CMP_W), .RES_W(RES_W)) u_res (
    .clk(clk), .rst_n(rst_n), .dp_done(dp_done), .dp_cmp(dp_cmp),
    .dp_msw(dp_msw), .dp_divmsw(dp_divmsw), .run_q(run_q),
    .basic_op(op_rd == '0), .stall_q(stall_rd), .cmp_q(cmp_rd),
    .msw_q(msw_rd), .div_q(divmsw_rd), .pend_q(pend_q),
    .done_evt(done_evt), .publish_evt(publish_evt)
  );

  bnl_trig_reg #(.W(TRIG_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .host_set_en(ctrl_wr),
    .host_mask(host_wdata[C_TRIG_LO +: TRIG_W]), .seq_clr_en(seq_clr_eff),
    .seq_data(seq_trig_wdata), .auto0(auto_trig), .trig_q(trig_rd)
  );

  bnl_seq_ctrl #(.STAT_W(STAT_W), .PROG_IN_RAM(PROG_IN_RAM)) u_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .w_rst(host_wdata[C_RST]),
    .run_vis(run_rd), .stat_wr(seq_stat_wr), .stat_wdata(seq_stat_wdata),
    .seq_rst_q(seq_rst_rd), .seq_en(seq_en), .stat_q(stat_rd),
    .prog_en(prog_mem_en), .data_en(data_mem_en)
  );
endmodule

// File: rtl/bn_launch_ctrl_chk.sv
module bn_launch_ctrl_chk #(
  parameter int OP_W   = 3,
  parameter int TRIG_W = 8,
  parameter int CMP_W  = 3,
  parameter int RES_W  = 12,
  parameter int HW_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_sel,
  input logic [HW_W-1:0]   host_wdata,
  input logic              run_rd,
  input logic              run_q,
  input logic              stall_rd,
  input logic [OP_W-1:0]   op_rd,
  input logic              seq_rst_rd,
  input logic [TRIG_W-1:0] trig_rd,
  input logic [CMP_W-1:0]  cmp_rd,
  input logic [RES_W-1:0]  msw_rd,
  input logic              done_evt,
  input logic              pend_q,
  input logic              seq_clr_eff
);
  // R4: an unstalled basic completion drops the run flag
  a_r4_done_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && !stall_rd |=> !run_q);

  // R5: a stalled completion keeps results and run, and parks the result
  a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && stall_rd |=> $stable(cmp_rd) && $stable(msw_rd) && run_q && pend_q);

  // R6: once stall reads 0 with a result parked, it is published next cycle
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !stall_rd |=> !pend_q && !run_q);

  // R9: without an effective sequencer clear, no trigger bit falls
  a_r9_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_clr_eff |=> ((trig_rd & $past(trig_rd)) == $past(trig_rd)));

  // R11: function writes while running leave the operation code alone
  a_r11_op_locked: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !host_sel && run_rd |=> $stable(op_rd));

  // R11: sequencer reset cannot be raised while running
  a_r11_rst_guard: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel && run_rd && host_wdata[0] && !seq_rst_rd |=> !seq_rst_rd);
endmodule

bind bn_launch_ctrl bn_launch_ctrl_chk #(
  .OP_W(OP_W), .TRIG_W(TRIG_W), .CMP_W(CMP_W), .RES_W(RES_W), .HW_W(HW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
  .host_wdata(host_wdata), .run_rd(run_rd), .run_q(run_q), .stall_rd(stall_rd),
  .op_rd(op_rd), .seq_rst_rd(seq_rst_rd), .trig_rd(trig_rd), .cmp_rd(cmp_rd),
  .msw_rd(msw_rd), .done_evt(done_evt), .pend_q(pend_q), .seq_clr_eff(seq_clr_eff)
);

// File: tb/bn_launch_ctrl_bench.sv
module bn_launch_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        host_wr = 0, host_sel = 0;
  logic [15:0] host_wdata = '0;
  logic        dp_done = 0;
  logic [2:0]  dp_cmp = '0;
  logic [11:0] dp_msw = '0, dp_divmsw = '0;
  logic        seq_trig_wr = 0, seq_stat_wr = 0, seq_run_clr = 0;
  logic [7:0]  seq_trig_wdata = '0, seq_stat_wdata = '0;

  logic        run_rd, stall_rd, seq_rst_rd, irq, prog_mem_en, data_mem_en, dp_start;
  logic [2:0]  op_rd, cmp_rd;
  logic [7:0]  trig_rd, stat_rd;
  logic [11:0] msw_rd, divmsw_rd;

  logic        r_run, r_stall, r_rst, r_irq, r_prog, r_data, r_start;
  logic [2:0]  r_op, r_cmp;
  logic [7:0]  r_trig, r_stat;
  logic [11:0] r_msw, r_div;

  bn_launch_ctrl u_bn_launch_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .run_rd(run_rd), .stall_rd(stall_rd), .op_rd(op_rd),
    .seq_rst_rd(seq_rst_rd), .trig_rd(trig_rd), .stat_rd(stat_rd), .cmp_rd(cmp_rd),
    .msw_rd(msw_rd), .divmsw_rd(divmsw_rd), .irq(irq), .prog_mem_en(prog_mem_en),
    .data_mem_en(data_mem_en), .dp_start(dp_start), .dp_done(dp_done),
    .dp_cmp(dp_cmp), .dp_msw(dp_msw), .dp_divmsw(dp_divmsw),
    .seq_trig_wr(seq_trig_wr), .seq_trig_wdata(seq_trig_wdata),
    .seq_stat_wr(seq_stat_wr), .seq_stat_wdata(seq_stat_wdata), .seq_run_clr(seq_run_clr)
  );

  bn_launch_ctrl #(.PROG_IN_RAM(1'b0)) u_bn_launch_ctrl_rom (
    .clk(clk), .rst_n(rst_n), .host_wr(1'b0), .host_sel(1'b0), .host_wdata(16'h0),
    .run_rd(r_run), .stall_rd(r_stall), .op_rd(r_op), .seq_rst_rd(r_rst),
    .trig_rd(r_trig), .stat_rd(r_stat), .cmp_rd(r_cmp), .msw_rd(r_msw),
    .divmsw_rd(r_div), .irq(r_irq), .prog_mem_en(r_prog), .data_mem_en(r_data),
    .dp_start(r_start), .dp_done(1'b0), .dp_cmp(3'h0), .dp_msw(12'h0),
    .dp_divmsw(12'h0), .seq_trig_wr(1'b0), .seq_trig_wdata(8'h0),
    .seq_stat_wr(1'b0), .seq_stat_wdata(8'h0), .seq_run_clr(1'b0)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0]  e_trig;
  logic [2:0]  e_cmp;
  logic [11:0] e_msw, e_div;

  function automatic logic [15:0] fw(bit run, bit stall, logic [2:0] op);
    return {11'h0, op, stall, run};
  endfunction

  function automatic logic [7:0] model_trig(logic [7:0] cur, bit hs, logic [7:0] hm,
                                            bit sc, logic [7:0] sd);
    logic [7:0] t;
    t = cur;
    if (sc) t = t & sd;
    if (hs) t = t | hm;
    return t;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic hwrite(bit sel, logic [15:0] d);
    host_wr = 1; host_sel = sel; host_wdata = d;
    tick();
    host_wr = 0;
  endtask

  task automatic done_pulse(logic [2:0] c, logic [11:0] m, logic [11:0] dv);
    dp_done = 1; dp_cmp = c; dp_msw = m; dp_divmsw = dv;
    tick();
    dp_done = 0;
  endtask

  initial begin
    #600000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    tick(); tick();
    rst_n = 1;
    tick();
    // R1 reset state
    check("R1 run", run_rd, 1); check("R1 irq", irq, 0);
    check("R1 seqrst", seq_rst_rd, 1); check("R1 trig", trig_rd, 0);
    check("R1 results", {cmp_rd, msw_rd, divmsw_rd}, 0);
    check("R1 stall/op", {stall_rd, op_rd}, 0);
    check("R13 rom reset", r_rst, 0);
    check("R13 rom routing", {r_prog, r_data}, 2'b01);
    check("R12 prog open", {prog_mem_en, data_mem_en}, 2'b10);

    // R12 sequencer inputs ignored while held
    seq_stat_wr = 1; seq_stat_wdata = 8'h01; seq_run_clr = 1;
    tick();
    seq_stat_wr = 0; seq_run_clr = 0;
    check("R12 stat ignored", stat_rd, 0); check("R12 run kept", run_rd, 1);

    // R11 clearing seq reset allowed while running
    hwrite(1, 16'h0000);
    check("R11 rst clear", seq_rst_rd, 0);
    check("R12 data open", {prog_mem_en, data_mem_en}, 2'b01);

    // sequencer first action
    seq_stat_wr = 1; seq_stat_wdata = 8'h01; seq_run_clr = 1;
    tick();
    seq_stat_wr = 0; seq_run_clr = 0;
    check("R2 run low", run_rd, 0); check("R2 irq high", irq, 1);
    seq_stat_wr = 1; seq_stat_wdata = 8'h00;
    tick();
    check("R2 stat0 low forces run", run_rd, 1); check("R2 irq", irq, 0);
    seq_stat_wdata = 8'h01;
    tick();
    seq_stat_wr = 0;
    check("R2 run restored", run_rd, 0);

    // R3 / R4 basic operation
    hwrite(0, fw(1, 0, 3'd0));
    check("R3 start", dp_start, 1); check("R3 run", run_rd, 1);
    tick();
    check("R3 start one cycle", dp_start, 0);
    done_pulse(3'b100, 12'h8a3, 12'h012);
    check("R4 cmp", cmp_rd, 3'b100); check("R4 msw", msw_rd, 12'h8a3);
    check("R4 div", divmsw_rd, 12'h012); check("R4 run cleared", run_rd, 0);

    // R5 / R6 stalled operation
    hwrite(0, fw(1, 1, 3'd0));
    done_pulse(3'b001, 12'hfff, 12'h800);
    tick();
    check("R5 msw held", msw_rd, 12'h8a3); check("R5 run held", run_rd, 1);
    hwrite(0, fw(1, 1, 3'd5));
    check("R11 op locked", op_rd, 0); check("R11 stall kept", stall_rd, 1);
    hwrite(0, fw(0, 0, 3'd0));
    check("R6 not yet", msw_rd, 12'h8a3); check("R6 run still", run_rd, 1);
    tick();
    check("R6 cmp", cmp_rd, 3'b001); check("R6 msw", msw_rd, 12'hfff);
    check("R6 div", divmsw_rd, 12'h800); check("R6 run cleared", run_rd, 0);

    // R7 / R10 complex operation
    e_trig = 8'h00;
    hwrite(0, fw(1, 0, 3'd3));
    e_trig = e_trig | 8'h01;
    check("R10 trig0", trig_rd, e_trig); check("R7 run", run_rd, 1);
    done_pulse(3'b010, 12'h111, 12'h222);
    check("R7 done ignored run", run_rd, 1); check("R7 done ignored msw", msw_rd, 12'hfff);
    hwrite(0, fw(0, 1, 3'd0));
    check("R11 stall while run", stall_rd, 1);
    seq_run_clr = 1; tick(); seq_run_clr = 0;
    check("R7 seq clears despite stall", run_rd, 0);
    hwrite(0, fw(0, 0, 3'd0));
    check("R3 op written", op_rd, 0);

    // R8 / R9 trigger rules
    hwrite(1, 16'ha400); e_trig = model_trig(e_trig, 1, 8'ha4, 0, 8'h0);
    check("R8 set", trig_rd, e_trig);
    hwrite(1, 16'h0000);
    check("R8 zero no effect", trig_rd, e_trig);
    seq_trig_wr = 1; seq_trig_wdata = 8'hf0; tick();
    e_trig = model_trig(e_trig, 0, 8'h0, 1, 8'hf0);
    check("R9 clear", trig_rd, e_trig);
    seq_trig_wdata = 8'hff; tick(); seq_trig_wr = 0;
    check("R9 ones no effect", trig_rd, e_trig);
    seq_trig_wr = 1; seq_trig_wdata = 8'h00;
    hwrite(1, 16'h0100); seq_trig_wr = 0;
    e_trig = model_trig(e_trig, 1, 8'h01, 1, 8'h00);
    check("R9 set wins", trig_rd, e_trig);

    // R11 seq reset guard
    hwrite(0, fw(1, 0, 3'd0));
    hwrite(1, 16'h0001);
    check("R11 rst blocked", seq_rst_rd, 0);
    done_pulse(3'b001, 12'h0a0, 12'h00b);
    hwrite(1, 16'h0001);
    check("R11 rst set idle", seq_rst_rd, 1);
    check("R12 prog open again", {prog_mem_en, data_mem_en}, 2'b10);
    seq_trig_wr = 1; seq_trig_wdata = 8'h00; tick(); seq_trig_wr = 0;
    check("R12 trig clr ignored", trig_rd, e_trig);
    hwrite(1, 16'h0000);

    // random basic operations with random stall
    e_cmp = 3'b001; e_msw = 12'h0a0; e_div = 12'h00b;
    for (int i = 0; i < 300; i++) begin
      bit s;
      int gap;
      logic [2:0] c;
      logic [11:0] m, dv;
      s = 1'($urandom);
      gap = int'($urandom_range(0, 3));
      c = 3'($urandom); m = 12'($urandom); dv = 12'($urandom);
      hwrite(0, fw(1, s, 3'd0));
      for (int k = 0; k < gap; k++) tick();
      done_pulse(c, m, dv);
      if (!s) begin
        e_cmp = c; e_msw = m; e_div = dv;
        check("R4 rand", {run_rd, cmp_rd, msw_rd, divmsw_rd}, {1'b0, e_cmp, e_msw, e_div});
      end else begin
        check("R5 rand", {run_rd, cmp_rd, msw_rd, divmsw_rd}, {1'b1, e_cmp, e_msw, e_div});
        hwrite(0, fw(0, 0, 3'd0));
        tick();
        e_cmp = c; e_msw = m; e_div = dv;
        check("R6 rand", {run_rd, cmp_rd, msw_rd, divmsw_rd}, {1'b0, e_cmp, e_msw, e_div});
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule